// File: doc/BRIEF.md
# Four-Way LRU Tag Cache

This block models the tag side of a small data cache: 256 bytes split into four sets of four ways, each line holding a 16-byte block. Every cycle it may accept one access. An access carries a kind (load, store, read-modify-write or instruction fetch) and a byte address. For each data access it decides whether the block is present. On a miss it chooses a line to fill. It reports whether an older line was pushed out, and whether that line held modified data that must be written back.

Within each set, replacement follows true least-recently-used order. Every hit and every fill makes the touched line the most recent one. The write policy is write-back with write-allocate, so a store marks its line modified. A read-modify-write behaves as a load followed at once by a store to the same block. Instruction fetches are ignored completely.

The block also keeps running totals of hits, misses and evictions. These totals stop at their maximum value rather than wrapping. It holds no data and drives no refill or writeback bus: a writeback shows only as a flag.

Top module: `lru_tag_cache`

## Requirements
- R1: The address splits as block offset bits [3:0], set index bits [5:4] and tag bits [ADDR_W-1:6]. Two addresses that differ only in the offset name the same block. Addresses that differ in the set bits name different blocks.
- R2: After reset every line in every set is invalid and all three counters read zero, so the first data access after reset misses.
- R3: An access with acc_valid high and a data kind produces res_valid high on the next cycle. Exactly one of res_hit or res_miss is high then: res_hit when a valid line in the indexed set holds the tag, res_miss otherwise.
- R4: A miss in a set that still has an invalid line fills that line and reports no eviction.
- R5: A miss in a full set evicts the line of that set that was accessed longest ago, and raises res_evict together with res_miss.
- R6: Both hits and fills make the touched line the most recently used line of its set. Replacement order follows the true access history.
- R7: A store or read-modify-write marks its line modified, whether it hits or fills. When a modified line is evicted, res_wb is high for that one result cycle. When a clean line is evicted, res_wb stays low.
- R8: A read-modify-write that misses adds one miss and one hit to the counters. One that hits adds two hits. In both cases the line becomes modified.
- R9: acc_kind encodes 2'b00 load, 2'b01 store, 2'b10 read-modify-write and 2'b11 instruction fetch. An instruction fetch produces no result and changes neither the line state nor the counters.
- R10: hit_count, miss_count and evict_count are CNT_W bits wide and reflect every access up to and including the one whose result is shown. Each counter saturates at its all-ones value and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access kind: 00 load, 01 store, 10 read-modify-write, 11 instruction |
| acc_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | Result of the previous cycle's data access |
| res_hit | output | 1 | The access found its block |
| res_miss | output | 1 | The access did not find its block |
| res_evict | output | 1 | A valid line was replaced |
| res_wb | output | 1 | The replaced line was modified and needs writeback |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |
| evict_count | output | CNT_W | Saturating eviction total |

## Verification
The hardest case to produce from the ports is an eviction whose victim is modified and was last touched by a hit long after the other lines were filled. The stimulus has to fill a set, mark a line modified, reorder recency with further hits, and only then force a miss. Directed sequences build exactly that history in one set while instruction fetches to conflicting tags are mixed in. A long stretch of random accesses over a few tags per set then reaches the counter saturation point, where a read-modify-write hit lands one below the maximum.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'b00,
        ACC_STORE  = 2'b01,
        ACC_MODIFY = 2'b10,
        ACC_INSTR  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic hit;
        logic evict;
        logic wb;
    } lookup_res_t;

    // Hit credit of one access: a read-modify-write always scores its store half as a hit.
    function automatic logic [1:0] hit_credit(acc_kind_e kind, logic hit);
        if (kind == ACC_MODIFY)
            return hit ? 2'd2 : 2'd1;
        return hit ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [1:0] miss_credit(logic hit);
        return hit ? 2'd0 : 2'd1;
    endfunction

    function automatic logic writes_line(acc_kind_e kind);
        return (kind == ACC_STORE) || (kind == ACC_MODIFY);
    endfunction

endpackage

// File: rtl/lru_set.sv
module lru_set
    import lru_cache_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_write,
    output lookup_res_t      res_o
);
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]  valid;
    logic [WAYS-1:0]  dirty;
    logic [TAG_W-1:0] tags [WAYS];
    logic [AGE_W-1:0] age  [WAYS];

    logic             hit, free_found;
    logic [AGE_W-1:0] hit_way, free_way, lru_way, target;
    logic [AGE_W-1:0] target_age;

    always_comb begin
        hit        = 1'b0;
        free_found = 1'b0;
        hit_way    = '0;
        free_way   = '0;
        lru_way    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid[w] && tags[w] == lk_tag) begin
                hit     = 1'b1;
                hit_way = AGE_W'(w);
            end
            if (!valid[w]) begin
                free_found = 1'b1;
                free_way   = AGE_W'(w);
            end
            if (age[w] == AGE_W'(WAYS - 1))
                lru_way = AGE_W'(w);
        end
        target     = hit ? hit_way : (free_found ? free_way : lru_way);
        target_age = age[target];
        res_o.hit   = hit;
        res_o.evict = !hit && !free_found;
        res_o.wb    = !hit && !free_found && dirty[lru_way];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            dirty <= '0;
            for (int w = 0; w < WAYS; w++) begin
                tags[w] <= '0;
                age[w]  <= AGE_W'(w);
            end
        end else if (upd_en) begin
            valid[target] <= 1'b1;
            tags[target]  <= lk_tag;
            dirty[target] <= hit ? (dirty[target] | lk_write) : lk_write;
            for (int w = 0; w < WAYS; w++) begin
                if (AGE_W'(w) == target)
                    age[w] <= '0;
                else if (age[w] < target_age)
                    age[w] <= age[w] + 1'b1;
            end
        end
    end

    // The age values of a set always form a permutation of 0..WAYS-1.
    logic [WAYS-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++)
            age_seen[age[w]] = 1'b1;
    end

    assert_age_perm_R6: assert property (@(posedge clk) disable iff (rst)
        &age_seen);

    assert_evict_full_R5: assert property (@(posedge clk) disable iff (rst)
        res_o.evict |-> &valid);

    assert_fill_marks_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !res_o.hit) |=> valid[$past(target)]);

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   inc,
    output logic [W-1:0] count
);
    logic [W:0] sum;

    always_comb sum = {1'b0, count} + (W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (sum[W])
            count <= '1;
        else
            count <= sum[W-1:0];
    end

    assert_sat_mono_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count >= $past(count));

    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (&count) |=> (&count));

endmodule

// File: rtl/lru_tag_cache.sv
module lru_tag_cache
    import lru_cache_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 4,
    parameter int SET_W    = 2,
    parameter int WAYS     = 4,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_evict,
    output logic              res_wb,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  evict_count
);
    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = ADDR_W - OFFSET_W - SET_W;
    localparam int NCNT  = 3;

    acc_kind_e        kind;
    logic             take;
    logic             wr;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] lk_tag;
    logic             offset_unused;

    assign kind          = acc_kind_e'(acc_kind);
    assign take          = acc_valid && (kind != ACC_INSTR);
    assign wr            = writes_line(kind);
    assign set_idx       = acc_addr[OFFSET_W +: SET_W];
    assign lk_tag        = acc_addr[ADDR_W-1 -: TAG_W];
    assign offset_unused = ^acc_addr[OFFSET_W-1:0];

    lookup_res_t set_res [SETS];
    lookup_res_t cur;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        lru_set #(
            .TAG_W (TAG_W),
            .WAYS  (WAYS)
        ) u_set (
            .clk      (clk),
            .rst      (rst),
            .upd_en   (take && (set_idx == SET_W'(s))),
            .lk_tag   (lk_tag),
            .lk_write (wr),
            .res_o    (set_res[s])
        );
    end

    assign cur = set_res[set_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_evict <= 1'b0;
            res_wb    <= 1'b0;
        end else begin
            res_valid <= take;
            res_hit   <= take && cur.hit;
            res_miss  <= take && !cur.hit;
            res_evict <= take && cur.evict;
            res_wb    <= take && cur.wb;
        end
    end

    logic [1:0]       inc [NCNT];
    logic [CNT_W-1:0] cnt [NCNT];

    always_comb begin
        inc[0] = take ? hit_credit(kind, cur.hit) : 2'd0;
        inc[1] = take ? miss_credit(cur.hit)      : 2'd0;
        inc[2] = (take && cur.evict) ? 2'd1       : 2'd0;
    end

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc[c]),
            .count (cnt[c])
        );
    end

    assign hit_count   = cnt[0];
    assign miss_count  = cnt[1];
    assign evict_count = cnt[2];

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_hit != res_miss));

    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(res_hit || res_miss || res_evict || res_wb));

    assert_wb_needs_evict_R7: assert property (@(posedge clk) disable iff (rst)
        res_wb |-> (res_evict && res_miss));

    assert_instr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == 2'b11) |=> (!res_valid && $stable(hit_count)
                                              && $stable(miss_count)));

    assert_evict_counted_R5: assert property (@(posedge clk) disable iff (rst)
        (res_evict && !(&evict_count)) |-> (evict_count != $past(evict_count)));

endmodule

// File: tb/sim_lru_tag_cache.sv
`timescale 1ns/1ps
module sim_lru_tag_cache;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic [1:0]        acc_kind = 2'b00;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              res_valid, res_hit, res_miss, res_evict, res_wb;
    logic [CNT_W-1:0]  hit_count, miss_count, evict_count;

    always #2 clk = ~clk;

    lru_tag_cache #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_kind    (acc_kind),
        .acc_addr    (acc_addr),
        .res_valid   (res_valid),
        .res_hit     (res_hit),
        .res_miss    (res_miss),
        .res_evict   (res_evict),
        .res_wb      (res_wb),
        .hit_count   (hit_count),
        .miss_count  (miss_count),
        .evict_count (evict_count)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string phase = "R2";

    // Behavioural model: timestamps per line, victim is the oldest stamp.
    int unsigned m_tag   [4][4];
    bit          m_val   [4][4];
    bit          m_dirty [4][4];
    int unsigned m_stamp [4][4];
    int unsigned now = 1;

    bit e_valid, e_hit, e_miss, e_evict, e_wb;
    int e_hits, e_misses, e_evicts;

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    function automatic logic [ADDR_W-1:0] mk(int tag, int set, int off);
        return ADDR_W'((tag << 6) | (set << 4) | off);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        check(res_valid == e_valid, "R9", "res_valid", res_valid, e_valid);
        check(res_hit   == e_hit,   "R3", "res_hit",   res_hit,   e_hit);
        check(res_miss  == e_miss,  "R3", "res_miss",  res_miss,  e_miss);
        check(res_evict == e_evict, "R5", "res_evict", res_evict, e_evict);
        check(res_wb    == e_wb,    "R7", "res_wb",    res_wb,    e_wb);
        check(int'(hit_count)   == e_hits,   "R10", "hit_count",   hit_count,   e_hits);
        check(int'(miss_count)  == e_misses, "R10", "miss_count",  miss_count,  e_misses);
        check(int'(evict_count) == e_evicts, "R10", "evict_count", evict_count, e_evicts);
    endtask

    task automatic model(bit v, logic [1:0] k, logic [ADDR_W-1:0] a);
        int s, t, w, victim;
        bit hit, wr;
        e_valid = v && (k != 2'b11);
        e_hit = 0; e_miss = 0; e_evict = 0; e_wb = 0;
        if (!e_valid) return;
        s  = int'(a[5:4]);
        t  = int'(a[ADDR_W-1:6]);
        wr = (k == 2'b01) || (k == 2'b10);
        hit = 0; w = -1;
        for (int i = 0; i < 4; i++)
            if (m_val[s][i] && m_tag[s][i] == t) begin hit = 1; w = i; end
        if (hit) begin
            m_dirty[s][w] = m_dirty[s][w] | wr;
        end else begin
            for (int i = 3; i >= 0; i--)
                if (!m_val[s][i]) w = i;
            if (w < 0) begin
                victim = 0;
                for (int i = 1; i < 4; i++)
                    if (m_stamp[s][i] < m_stamp[s][victim]) victim = i;
                w = victim;
                e_evict = 1;
                e_wb = m_dirty[s][w];
            end
            m_val[s][w]   = 1;
            m_tag[s][w]   = t;
            m_dirty[s][w] = wr;
        end
        m_stamp[s][w] = now;
        now++;
        e_hit  = hit;
        e_miss = !hit;
        e_hits   = sat(e_hits + (hit ? 1 : 0) + ((k == 2'b10) ? 1 : 0));
        e_misses = sat(e_misses + (hit ? 0 : 1));
        e_evicts = sat(e_evicts + (e_evict ? 1 : 0));
    endtask

    task automatic step(bit v, logic [1:0] k, logic [ADDR_W-1:0] a);
        @(negedge clk);
        compare();
        acc_valid = v;
        acc_kind  = k;
        acc_addr  = a;
        model(v, k, a);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 4; i++) begin
                m_val[s][i] = 0; m_dirty[s][i] = 0; m_tag[s][i] = 0; m_stamp[s][i] = 0;
            end
        e_valid = 0; e_hit = 0; e_miss = 0; e_evict = 0; e_wb = 0;
        e_hits = 0; e_misses = 0; e_evicts = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state, then the very first access misses
        phase = "R2";
        step(0, 2'b00, '0);
        step(1, 2'b00, mk(1, 0, 0));

        // R1: offset bits select nothing, set bits do
        phase = "R1";
        step(1, 2'b00, mk(1, 0, 15));
        step(1, 2'b00, mk(1, 1, 0));
        step(1, 2'b00, mk(1, 1, 7));
        step(1, 2'b00, mk(2, 0, 3));

        // R4: fill the rest of set 2 without evictions
        phase = "R4";
        for (int t = 0; t < 4; t++) step(1, 2'b00, mk(t + 3, 2, 0));

        // R6: hits reorder recency, then misses evict the oldest
        phase = "R6";
        step(1, 2'b00, mk(3, 2, 0));
        step(1, 2'b00, mk(4, 2, 0));
        step(1, 2'b00, mk(9, 2, 0));
        step(1, 2'b00, mk(10, 2, 0));
        step(1, 2'b00, mk(3, 2, 0));

        // R7: dirty victim versus clean victim
        phase = "R7";
        for (int t = 0; t < 4; t++) step(1, 2'b00, mk(t + 20, 3, 0));
        step(1, 2'b01, mk(20, 3, 4));
        step(1, 2'b00, mk(21, 3, 0));
        step(1, 2'b00, mk(22, 3, 0));
        step(1, 2'b00, mk(23, 3, 0));
        step(1, 2'b00, mk(30, 3, 0));
        step(1, 2'b00, mk(31, 3, 0));
        step(1, 2'b01, mk(32, 3, 0));
        step(1, 2'b00, mk(33, 3, 0));
        step(1, 2'b00, mk(34, 3, 0));
        step(1, 2'b00, mk(35, 3, 0));
        step(1, 2'b00, mk(36, 3, 0));

        // R8: read-modify-write miss then hit, later evicted dirty
        phase = "R8";
        step(1, 2'b10, mk(40, 1, 0));
        step(1, 2'b10, mk(40, 1, 8));
        for (int t = 0; t < 4; t++) step(1, 2'b00, mk(t + 41, 1, 0));

        // R9: instruction fetches to conflicting tags leave everything alone
        phase = "R9";
        for (int t = 0; t < 6; t++) step(1, 2'b11, mk(t + 50, 1, 0));
        step(1, 2'b00, mk(42, 1, 0));
        step(1, 2'b11, mk(60, 1, 0));
        step(0, 2'b00, mk(61, 1, 0));
        step(1, 2'b00, mk(43, 1, 0));

        // R10: random traffic over few tags drives counters into saturation
        phase = "R10";
        for (int n = 0; n < 1500; n++)
            step(1, 2'($urandom_range(0, 3)),
                 mk(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 15))));
        step(0, 2'b00, '0);
        step(0, 2'b00, '0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule